// File: doc/BRIEF.md
# Event-Driven Set/Reset PWM Timer

This block is a PWM generator built around an up-counter. The output is not produced by comparing a duty value against the count. It is a flip-flop that is driven high by any event listed in a set mask and driven low by any event listed in a reset mask. There are five candidate events: four compare matches and the period rollover (update) event. Software chooses the waveform by choosing which events feed each mask. For example, setting on compare 1 and resetting on compare 2 places the high pulse anywhere inside the period.

The period and compare values pass through preload registers. Their active copies change only at rollover, so a write never breaks the period that is running. A half mode supports variable-frequency square waves. In that mode, each period write also loads half the new period into the compare-1 preload, so the duty stays at 50% at every frequency.

Top module: `pwm_evt_timer`

## Requirements
- R1: While `cnt_en` is high, the internal counter advances by one per clock from 0 up to the active period. In the cycle where it equals the active period, it returns to 0 at the next edge. That wrap cycle is the update event, and it lasts exactly one clock.
- R2: Registers are written through `wr_en`/`wr_addr`/`wr_data`. Address 0 is the period, addresses 1 to 4 are compares 1 to 4, address 5 is the set mask, address 6 is the reset mask, and address 7 is the mode (bit 0 = half mode). In both masks, bit 1 selects the update event and bits 3 to 6 select compares 1 to 4. A compare event is an enabled cycle whose count equals that compare's active value. `pwm_out` is registered and takes its new level at the edge that ends the event cycle.
- R3: When compare events from the set mask and from the reset mask occur in the same cycle, the output goes low.
- R4: An update-sourced set or reset is applied after the compare events of the same cycle, so it decides the final level. If the update event appears in both masks, the result is low.
- R5: Period and compare writes go to preload registers. These reach the active copies only at an update event, and a write in the same cycle as an update takes effect at the following update. Mask and mode writes take effect on the next cycle.
- R6: With half mode on, a write to the period also writes the period shifted right by one into the compare-1 preload. Both values become active at the next update.
- R7: While `cnt_en` is low, the counter and `pwm_out` hold their values.
- R8: Synchronous reset clears the counter, every preload and active register, the masks and the mode, and drives `pwm_out` low. Because the active period is then 0, the first enabled cycle after reset is an update event.
- R9: With period 0x1FF, compare 1 = 0x80, compare 2 = 0x150, set mask 0x8 and reset mask 0x10, the output is high for 0xD0 cycles in every 0x200-cycle period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | CW | Write data |
| pwm_out | output | 1 | PWM output |

## Verification
The bench targets the collisions between events. These are a compare that lands on the wrap count, equal set and reset compares, and the update event appearing in both masks. A design with the wrong priority or ordering would hold the output at the wrong level across whole periods. The bench also writes compares and the period in the middle of a period and in the exact cycle of an update. A design without proper shadowing would move the edge within the current period, or one period too early. Half-mode period writes are checked by the length of the high phase. A wrong shift or a compare loaded directly into the active register would give an uneven duty or a glitch on the first period.

// File: rtl/pwm_evt_timer.sv
module pwm_evt_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_en,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          pwm_out
);
  localparam int NCMP = 4;
  localparam int MW   = 3 + NCMP;
  localparam logic [MW-1:0] MASK_KEEP = {{NCMP{1'b1}}, 3'b010};

  logic [CW-1:0]            cnt_q;
  logic [CW-1:0]            per_pre, per_act;
  logic [NCMP-1:0][CW-1:0]  cmp_pre, cmp_act;
  logic [MW-1:0]            set_msk, rst_msk;
  logic                     half_q;
  logic                     upd;
  logic [NCMP-1:0]          hit;
  logic                     cmp_set, cmp_rst, lvl;

  assign upd = cnt_en && (cnt_q == per_act);

  for (genvar i = 0; i < NCMP; i++) begin : g_hit
    assign hit[i] = cnt_en && (cnt_q == cmp_act[i]);
  end

  assign cmp_set = |(hit & set_msk[MW-1:3]);
  assign cmp_rst = |(hit & rst_msk[MW-1:3]);

  always_comb begin
    lvl = pwm_out;
    if (cmp_set) lvl = 1'b1;
    if (cmp_rst) lvl = 1'b0;
    if (upd && set_msk[1]) lvl = 1'b1;
    if (upd && rst_msk[1]) lvl = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      per_act <= '0;
      cmp_act <= '0;
      pwm_out <= 1'b0;
    end else begin
      pwm_out <= lvl;
      if (upd) begin
        cnt_q   <= '0;
        per_act <= per_pre;
        cmp_act <= cmp_pre;
      end else if (cnt_en) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      per_pre <= '0;
      cmp_pre <= '0;
      set_msk <= '0;
      rst_msk <= '0;
      half_q  <= 1'b0;
    end else if (wr_en) begin
      for (int i = 0; i < NCMP; i++)
        if (wr_addr == 3'(i + 1)) cmp_pre[i] <= wr_data;
      case (wr_addr)
        3'd0: begin
          per_pre <= wr_data;
          if (half_q) cmp_pre[0] <= wr_data >> 1;
        end
        3'd5: set_msk <= wr_data[MW-1:0] & MASK_KEEP;
        3'd6: rst_msk <= wr_data[MW-1:0] & MASK_KEEP;
        3'd7: half_q  <= wr_data[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pwm_evt_timer_chk.sv
module pwm_evt_timer_chk #(
  parameter int CW = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                cnt_en,
  input logic                pwm_out,
  input logic [CW-1:0]       cnt_q,
  input logic [CW-1:0]       per_act,
  input logic [3:0][CW-1:0]  cmp_act,
  input logic [6:0]          set_msk,
  input logic [6:0]          rst_msk
);
  logic wrap;
  logic [3:0] chits;
  assign wrap = cnt_en && (cnt_q == per_act);
  for (genvar i = 0; i < 4; i++) begin : g_c
    assign chits[i] = cnt_en && (cnt_q == cmp_act[i]);
  end

  a_r1_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= per_act);
  a_r1_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    wrap |=> cnt_q == '0);
  a_r5_per_shadow: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(per_act));
  a_r5_cmp_shadow: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(cmp_act));
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(pwm_out) && $stable(cnt_q));
  a_r4_upd_set_last: assert property (@(posedge clk) disable iff (rst)
    wrap && set_msk[1] && !rst_msk[1] |=> pwm_out);
  a_r4_upd_rst_last: assert property (@(posedge clk) disable iff (rst)
    wrap && rst_msk[1] |=> !pwm_out);
  a_r3_cmp_rst_wins: assert property (@(posedge clk) disable iff (rst)
    !wrap && (|(chits & rst_msk[6:3])) |=> !pwm_out);
  a_r8_reset_low: assert property (@(posedge clk)
    rst |=> !pwm_out && cnt_q == '0);
endmodule

bind pwm_evt_timer pwm_evt_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .pwm_out(pwm_out),
  .cnt_q(cnt_q), .per_act(per_act), .cmp_act(cmp_act),
  .set_msk(set_msk), .rst_msk(rst_msk)
);

// File: tb/tb_pwm_evt_timer.sv
`timescale 1ns/1ps
module tb_pwm_evt_timer;
  localparam int CW = 16;
  localparam logic [6:0] KEEP = 7'b1111010;

  logic clk = 1'b0, rst = 1'b1, cnt_en = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic pwm_out;

  int total = 0, bad = 0;
  bit finished = 0, chk_on = 0;
  string cur_tag = "R8";

  pwm_evt_timer #(.CW(CW)) dut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out));

  always #4 clk = ~clk;

  // spec model
  logic [CW-1:0] m_cnt, m_per, p_per;
  logic [CW-1:0] m_cmp [4], p_cmp [4];
  logic [6:0] m_set, m_rst;
  logic m_half, m_out;

  always @(posedge clk) begin : model
    logic u, s, r, nx;
    if (rst) begin
      m_cnt = '0; m_per = '0; p_per = '0; m_set = '0; m_rst = '0;
      m_half = 0; m_out = 0;
      for (int i = 0; i < 4; i++) begin m_cmp[i] = '0; p_cmp[i] = '0; end
    end else begin
      u = cnt_en && m_cnt == m_per;
      s = 0; r = 0;
      for (int i = 0; i < 4; i++)
        if (cnt_en && m_cnt == m_cmp[i]) begin
          if (m_set[3+i]) s = 1;
          if (m_rst[3+i]) r = 1;
        end
      nx = m_out;
      if (s) nx = 1;
      if (r) nx = 0;
      if (u && m_set[1]) nx = 1;
      if (u && m_rst[1]) nx = 0;
      m_out = nx;
      if (u) begin
        m_cnt = '0; m_per = p_per;
        for (int i = 0; i < 4; i++) m_cmp[i] = p_cmp[i];
      end else if (cnt_en) m_cnt = m_cnt + 1'b1;
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin p_per = wr_data; if (m_half) p_cmp[0] = wr_data >> 1; end
          3'd1, 3'd2, 3'd3, 3'd4: p_cmp[wr_addr - 3'd1] = wr_data;
          3'd5: m_set = wr_data[6:0] & KEEP;
          3'd6: m_rst = wr_data[6:0] & KEEP;
          default: m_half = wr_data[0];
        endcase
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk)
    if (chk_on && !rst) check(cur_tag, {31'd0, pwm_out}, {31'd0, m_out});

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_reset();
    rst = 1; cnt_en = 0;
    step(2);
    rst = 0;
    check("R8", {31'd0, pwm_out}, 32'd0);
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) h++;
    end
  endtask

  initial begin
    int h;
    logic held;
    void'($urandom(32'd1234));
    step(1);
    do_reset();
    chk_on = 1;

    // R9: set on compare 1, reset on compare 2
    cur_tag = "R9";
    wr(3'd0, 16'h1FF); wr(3'd1, 16'h80); wr(3'd2, 16'h150);
    wr(3'd5, 16'h8);   wr(3'd6, 16'h10);
    check("R8", {31'd0, pwm_out}, 32'd0);
    cnt_en = 1;
    step(700);
    count_high(512, h);
    check("R9", h, 32'hD0);

    // R5: mid-period compare change waits for rollover
    cur_tag = "R5";
    wr(3'd2, 16'h100);
    step(1200);
    count_high(512, h);
    check("R5", h, 32'h80);
    wr(3'd0, 16'h40);
    step(600);

    // R7: enable low holds output
    cur_tag = "R7";
    cnt_en = 0;
    held = pwm_out;
    step(37);
    check("R7", {31'd0, pwm_out}, {31'd0, held});
    cnt_en = 1;
    step(100);

    // R4: compare reset on the wrap count loses to update set
    do_reset();
    cur_tag = "R4";
    wr(3'd0, 16'd20); wr(3'd1, 16'd20);
    wr(3'd5, 16'h2);  wr(3'd6, 16'h8);
    cnt_en = 1;
    step(30);
    count_high(63, h);
    check("R4", h, 32'd63);
    wr(3'd6, 16'h0A);
    step(30);
    count_high(42, h);
    check("R4", h, 32'd0);

    // R3: equal set/reset compares, reset wins
    do_reset();
    cur_tag = "R3";
    wr(3'd0, 16'd15); wr(3'd1, 16'd5); wr(3'd2, 16'd5);
    wr(3'd5, 16'h8);  wr(3'd6, 16'h10);
    cnt_en = 1;
    step(20);
    count_high(48, h);
    check("R3", h, 32'd0);

    // R6: half mode, set on update, reset on compare 1
    do_reset();
    cur_tag = "R6";
    wr(3'd7, 16'h1); wr(3'd5, 16'h2); wr(3'd6, 16'h8);
    wr(3'd0, 16'h20);
    cnt_en = 1;
    step(40);
    count_high(33, h);
    check("R6", h, 32'd17);
    wr(3'd0, 16'h0E);
    step(40);
    count_high(15, h);
    check("R6", h, 32'd8);

    // R1/R2: constrained random
    do_reset();
    cur_tag = "R2";
    for (int c = 0; c < 6000; c++) begin
      if (c % 1500 == 0) cur_tag = (c / 1500) % 2 ? "R1" : "R2";
      cnt_en = ($urandom % 8) != 0;
      if (($urandom % 4) == 0) begin
        logic [2:0] a;
        a = 3'($urandom % 8);
        wr_en = 1; wr_addr = a;
        wr_data = (a >= 3'd5) ? CW'($urandom % 128) : CW'($urandom % 40);
      end else wr_en = 0;
      @(negedge clk);
    end
    wr_en = 0;

    finished = 1;
    chk_on = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule